// File: doc/BRIEF.md
# Harris Corner Response Engine

This block turns a raster stream of signed horizontal and vertical gradient samples into a per-pixel corner strength. For every valid sample it forms the three gradient products (xx, yy and xy), smooths each over a 5×5 window of rounded shape, and scores the result with the Harris measure, using a fixed sensitivity of one sixteenth. A programmable threshold then decides which scores pass. Any score that does not pass comes out as zero.

The stream carries one sample per valid cycle, with flags that mark the start and end of each line and of each frame. Four internal line stores hold the gradients of the rows above. These stores advance only on valid cycles, so any amount of idle time inside a line or between lines is allowed. Every line of a frame has the same length, which may be at most the configured maximum. The output stream has the same shape as the input and is delayed by a fixed five cycles. The score emitted with the sample at row r, column c describes the window that covers rows r-4..r and columns c-4..c, whose centre is at (r-2, c-2). Positions above the first row or left of the first column count as zero gradient.

Top module: `harris_corner_engine`

## Requirements
- R1: In the cycle that follows a reset, `out_valid`, all four output position flags and `out_metric` are zero.
- R2: Each of the five output flags equals the matching input flag from exactly five clock cycles earlier. This holds whether or not the cycle is valid.
- R3: For a valid sample at row r, column c, each product is summed over window rows r-k and columns c-j, with k and j running from 0 to 4. The tap weight depends on the pair (min, max) of |k-2| and |j-2|: (0,0)=8, (0,1)=6, (0,2)=2, (1,1)=4, (1,2)=1, (2,2)=0. The weights total 64. Each sum is divided by 64 with an arithmetic right shift, which rounds toward minus infinity, so the smoothed xx and yy terms are never negative.
- R4: The raw score is Sxx·Syy − Sxy² − ((Sxx+Syy)² >> 4), computed at a width where no overflow is possible.
- R5: `out_metric` is nonzero only when the raw score is strictly greater than `thresh`. A score equal to the threshold gives zero.
- R6: A score that passes R5 is clamped to 2^OUT_W−1. A negative score never appears at the output.
- R7: Window taps above the first row of the frame, or left of the first sample of a line, count as zero gradient.
- R8: Invalid cycles neither shift the window nor advance the line stores, and they emit zero data. A line may hold at most MAX_WIDTH samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on the gradient inputs is valid |
| in_hstart | input | 1 | First sample of a line |
| in_hend | input | 1 | Last sample of a line |
| in_vstart | input | 1 | First sample of a frame |
| in_vend | input | 1 | Last sample of a frame |
| in_gx | input | GRAD_W | Signed horizontal gradient |
| in_gy | input | GRAD_W | Signed vertical gradient |
| thresh | input | OUT_W | Unsigned detection threshold |
| out_valid | output | 1 | Delayed valid flag |
| out_hstart | output | 1 | Delayed line-start flag |
| out_hend | output | 1 | Delayed line-end flag |
| out_vstart | output | 1 | Delayed frame-start flag |
| out_vend | output | 1 | Delayed frame-end flag |
| out_metric | output | OUT_W | Clamped corner score, or zero |

## Verification
On every cycle, the assertions check four things: the quiet output state after reset, the five-cycle flag delay, that the smoothed xx and yy terms are never negative, and that any nonzero score lies above the threshold it was compared against. They also check that no line runs past the line-store depth. The tap weights, the 1/16 trace term, zero padding at the top and left edges, clamping, and the skipping of idle cycles can only be shown by the bench's scenarios. The bench covers these with full-scale random gradients, idle gaps inside and between lines, a flat edge whose score goes negative, a pattern that saturates the output, and a line of the maximum length.

// File: rtl/harris_pkg.sv
package harris_pkg;

    typedef struct packed {
        logic valid;
        logic hstart;
        logic hend;
        logic vstart;
        logic vend;
    } flags_t;

    localparam int TAPS       = 5;
    localparam int NORM_SHIFT = 6;
    localparam int K_SHIFT    = 4;
    localparam int PIPE_LAT   = 5;

    // Rounded 5x5 smoothing weight; corners are zero, total is 64.
    function automatic int tap_weight(input int r, input int c);
        int dr, dc, lo, hi;
        dr = (r > 2) ? r - 2 : 2 - r;
        dc = (c > 2) ? c - 2 : 2 - c;
        lo = (dr < dc) ? dr : dc;
        hi = (dr < dc) ? dc : dr;
        if (hi == 0)              return 8;
        if (lo == 0 && hi == 1)   return 6;
        if (lo == 0 && hi == 2)   return 2;
        if (lo == 1 && hi == 1)   return 4;
        if (lo == 1 && hi == 2)   return 1;
        return 0;
    endfunction

endpackage

// File: rtl/hc_line_store.sv
module hc_line_store
    import harris_pkg::*;
#(
    parameter int GRAD_W    = 8,
    parameter int MAX_WIDTH = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take,
    input  logic                     line_first,
    input  logic                     frame_first,
    input  logic signed [GRAD_W-1:0] in_gx,
    input  logic signed [GRAD_W-1:0] in_gy,
    output logic signed [GRAD_W-1:0] col_gx [TAPS],
    output logic signed [GRAD_W-1:0] col_gy [TAPS]
);
    localparam int AW    = (MAX_WIDTH > 2) ? $clog2(MAX_WIDTH) : 1;
    localparam int LINES = TAPS - 1;
    localparam int EW    = 2 * GRAD_W;

    logic [AW-1:0] col_cnt;
    logic [AW-1:0] addr;
    logic [2:0]    row_cnt;
    logic [2:0]    cur_row;
    logic          line_full;
    logic [EW-1:0] rd [LINES];

    assign addr = line_first ? '0 : col_cnt;

    always_comb begin
        if (line_first) begin
            if (frame_first)              cur_row = 3'd0;
            else if (row_cnt == 3'd4)     cur_row = 3'd4;
            else                          cur_row = row_cnt + 3'd1;
        end else begin
            cur_row = row_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_cnt   <= '0;
            row_cnt   <= '0;
            line_full <= 1'b0;
        end else if (take) begin
            col_cnt   <= addr + AW'(1);
            row_cnt   <= cur_row;
            line_full <= (int'(addr) == MAX_WIDTH - 1);
        end
    end

    for (genvar k = 0; k < LINES; k++) begin : g_line
        logic [EW-1:0] store [MAX_WIDTH];
        logic [EW-1:0] wr;
        if (k == 0) begin : g_head
            assign wr = {in_gx, in_gy};
        end else begin : g_tail
            assign wr = rd[k-1];
        end
        always_ff @(posedge clk) begin
            if (take) store[addr] <= wr;
        end
        assign rd[k] = store[addr];
    end

    always_comb begin
        col_gx[0] = in_gx;
        col_gy[0] = in_gy;
        for (int k = 1; k < TAPS; k++) begin
            if (cur_row >= 3'(k)) begin
                col_gx[k] = $signed(rd[k-1][EW-1:GRAD_W]);
                col_gy[k] = $signed(rd[k-1][GRAD_W-1:0]);
            end else begin
                col_gx[k] = '0;
                col_gy[k] = '0;
            end
        end
    end

    // R8: a line never holds more samples than the store depth
    assert_line_fits_R8: assert property (@(posedge clk) disable iff (rst)
        (take && !line_first) |-> !line_full);

endmodule

// File: rtl/hc_window_sum.sv
module hc_window_sum
    import harris_pkg::*;
#(
    parameter int GRAD_W = 8,
    parameter int PROD_W = 2 * GRAD_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     take,
    input  logic                     line_first,
    input  logic signed [GRAD_W-1:0] col_gx [TAPS],
    input  logic signed [GRAD_W-1:0] col_gy [TAPS],
    output logic signed [PROD_W-1:0] sxx,
    output logic signed [PROD_W-1:0] syy,
    output logic signed [PROD_W-1:0] sxy
);
    localparam int ACC_W = PROD_W + NORM_SHIFT + 2;

    logic                     p_take, p_first;
    logic signed [PROD_W-1:0] pxx [TAPS];
    logic signed [PROD_W-1:0] pyy [TAPS];
    logic signed [PROD_W-1:0] pxy [TAPS];

    logic signed [PROD_W-1:0] wxx [TAPS][TAPS];
    logic signed [PROD_W-1:0] wyy [TAPS][TAPS];
    logic signed [PROD_W-1:0] wxy [TAPS][TAPS];

    logic signed [ACC_W-1:0]  acc_xx, acc_yy, acc_xy;

    // Stage 1: products of one column of the window
    always_ff @(posedge clk) begin
        if (rst) begin
            p_take  <= 1'b0;
            p_first <= 1'b0;
        end else begin
            p_take  <= take;
            p_first <= take && line_first;
        end
        for (int r = 0; r < TAPS; r++) begin
            pxx[r] <= PROD_W'(col_gx[r]) * PROD_W'(col_gx[r]);
            pyy[r] <= PROD_W'(col_gy[r]) * PROD_W'(col_gy[r]);
            pxy[r] <= PROD_W'(col_gx[r]) * PROD_W'(col_gy[r]);
        end
    end

    // Stage 2: horizontal window, cleared to the left of a line start
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < TAPS; r++) begin
                for (int j = 0; j < TAPS; j++) begin
                    wxx[r][j] <= '0;
                    wyy[r][j] <= '0;
                    wxy[r][j] <= '0;
                end
            end
        end else if (p_take) begin
            for (int r = 0; r < TAPS; r++) begin
                wxx[r][0] <= pxx[r];
                wyy[r][0] <= pyy[r];
                wxy[r][0] <= pxy[r];
                for (int j = 1; j < TAPS; j++) begin
                    wxx[r][j] <= p_first ? '0 : wxx[r][j-1];
                    wyy[r][j] <= p_first ? '0 : wyy[r][j-1];
                    wxy[r][j] <= p_first ? '0 : wxy[r][j-1];
                end
            end
        end
    end

    always_comb begin
        acc_xx = '0;
        acc_yy = '0;
        acc_xy = '0;
        for (int r = 0; r < TAPS; r++) begin
            for (int j = 0; j < TAPS; j++) begin
                acc_xx += ACC_W'(wxx[r][j]) * ACC_W'(tap_weight(r, j));
                acc_yy += ACC_W'(wyy[r][j]) * ACC_W'(tap_weight(r, j));
                acc_xy += ACC_W'(wxy[r][j]) * ACC_W'(tap_weight(r, j));
            end
        end
    end

    // Stage 3: normalised sums
    always_ff @(posedge clk) begin
        if (rst) begin
            sxx <= '0;
            syy <= '0;
            sxy <= '0;
        end else begin
            sxx <= PROD_W'(acc_xx >>> NORM_SHIFT);
            syy <= PROD_W'(acc_yy >>> NORM_SHIFT);
            sxy <= PROD_W'(acc_xy >>> NORM_SHIFT);
        end
    end

    // R3: smoothed squares stay non-negative
    assert_square_sums_nonneg_R3: assert property (@(posedge clk) disable iff (rst)
        (sxx >= 0) && (syy >= 0));

endmodule

// File: rtl/hc_response.sv
module hc_response
    import harris_pkg::*;
#(
    parameter int PROD_W = 16,
    parameter int OUT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [PROD_W-1:0] sxx,
    input  logic signed [PROD_W-1:0] syy,
    input  logic signed [PROD_W-1:0] sxy,
    input  logic [OUT_W-1:0]         thresh,
    output logic [OUT_W-1:0]         resp
);
    localparam int MW = 2 * PROD_W + 4;
    localparam logic signed [MW-1:0] OUT_MAX = {{(MW-OUT_W){1'b0}}, {OUT_W{1'b1}}};

    logic signed [MW-1:0] det, tr, score, score_q, thr_ext;

    always_comb begin
        det   = MW'(sxx) * MW'(syy) - MW'(sxy) * MW'(sxy);
        tr    = MW'(sxx) + MW'(syy);
        score = det - ((tr * tr) >>> K_SHIFT);
    end

    // Stage 4: raw score
    always_ff @(posedge clk) begin
        if (rst) score_q <= '0;
        else     score_q <= score;
    end

    assign thr_ext = $signed({{(MW-OUT_W){1'b0}}, thresh});

    // Stage 5: threshold gate, clip and clamp
    always_ff @(posedge clk) begin
        if (rst)                      resp <= '0;
        else if (score_q <= thr_ext)  resp <= '0;
        else if (score_q > OUT_MAX)   resp <= '1;
        else                          resp <= OUT_W'(score_q);
    end

    // R5: a passing score lies above the threshold it was judged against
    assert_above_threshold_R5: assert property (@(posedge clk) disable iff (rst)
        (resp != '0) |-> ((resp > $past(thresh)) || (resp == {OUT_W{1'b1}})));

endmodule

// File: rtl/harris_corner_engine.sv
module harris_corner_engine
    import harris_pkg::*;
#(
    parameter int GRAD_W    = 8,
    parameter int MAX_WIDTH = 64,
    parameter int OUT_W     = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     in_hstart,
    input  logic                     in_hend,
    input  logic                     in_vstart,
    input  logic                     in_vend,
    input  logic signed [GRAD_W-1:0] in_gx,
    input  logic signed [GRAD_W-1:0] in_gy,
    input  logic [OUT_W-1:0]         thresh,
    output logic                     out_valid,
    output logic                     out_hstart,
    output logic                     out_hend,
    output logic                     out_vstart,
    output logic                     out_vend,
    output logic [OUT_W-1:0]         out_metric
);
    localparam int PROD_W = 2 * GRAD_W;

    logic signed [GRAD_W-1:0] col_gx [TAPS];
    logic signed [GRAD_W-1:0] col_gy [TAPS];
    logic signed [PROD_W-1:0] sxx, syy, sxy;
    logic [OUT_W-1:0]         resp;
    logic                     line_first, frame_first;
    flags_t                   flag_pipe [PIPE_LAT];
    flags_t                   flag_out;
    logic [2:0]               fill;

    assign line_first  = in_valid && in_hstart;
    assign frame_first = in_valid && in_vstart;

    hc_line_store #(.GRAD_W(GRAD_W), .MAX_WIDTH(MAX_WIDTH)) u_lines (
        .clk         (clk),
        .rst         (rst),
        .take        (in_valid),
        .line_first  (line_first),
        .frame_first (frame_first),
        .in_gx       (in_gx),
        .in_gy       (in_gy),
        .col_gx      (col_gx),
        .col_gy      (col_gy)
    );

    hc_window_sum #(.GRAD_W(GRAD_W), .PROD_W(PROD_W)) u_window (
        .clk        (clk),
        .rst        (rst),
        .take       (in_valid),
        .line_first (line_first),
        .col_gx     (col_gx),
        .col_gy     (col_gy),
        .sxx        (sxx),
        .syy        (syy),
        .sxy        (sxy)
    );

    hc_response #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_resp (
        .clk    (clk),
        .rst    (rst),
        .sxx    (sxx),
        .syy    (syy),
        .sxy    (sxy),
        .thresh (thresh),
        .resp   (resp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_LAT; i++) flag_pipe[i] <= '0;
        end else begin
            flag_pipe[0] <= '{valid: in_valid, hstart: in_hstart, hend: in_hend,
                              vstart: in_vstart, vend: in_vend};
            for (int i = 1; i < PIPE_LAT; i++) flag_pipe[i] <= flag_pipe[i-1];
        end
    end

    assign flag_out   = flag_pipe[PIPE_LAT-1];
    assign out_valid  = flag_out.valid;
    assign out_hstart = flag_out.hstart;
    assign out_hend   = flag_out.hend;
    assign out_vstart = flag_out.vstart;
    assign out_vend   = flag_out.vend;
    assign out_metric = flag_out.valid ? resp : '0;

    always_ff @(posedge clk) begin
        if (rst)              fill <= '0;
        else if (fill != 3'd5) fill <= fill + 3'd1;
    end

    // R1: quiet outputs straight after reset
    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_metric == '0));

    // R2: flags emerge five cycles after they enter
    assert_flag_delay_R2: assert property (@(posedge clk) disable iff (rst)
        (fill == 3'd5) |-> (out_valid == $past(in_valid, 5) &&
                            out_hstart == $past(in_hstart, 5) &&
                            out_vend == $past(in_vend, 5)));

endmodule

// File: tb/harris_corner_engine_bench.sv
module harris_corner_engine_bench;
    localparam int GW  = 8;
    localparam int MW  = 64;
    localparam int OW  = 16;
    localparam int LAT = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 0, in_hstart = 0, in_hend = 0, in_vstart = 0, in_vend = 0;
    logic signed [GW-1:0] in_gx = '0, in_gy = '0;
    logic [OW-1:0] thresh = '0;
    logic out_valid, out_hstart, out_hend, out_vstart, out_vend;
    logic [OW-1:0] out_metric;

    always #4 clk = ~clk;

    harris_corner_engine #(.GRAD_W(GW), .MAX_WIDTH(MW), .OUT_W(OW)) u_harris_corner_engine (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_hstart(in_hstart), .in_hend(in_hend),
        .in_vstart(in_vstart), .in_vend(in_vend),
        .in_gx(in_gx), .in_gy(in_gy), .thresh(thresh),
        .out_valid(out_valid), .out_hstart(out_hstart), .out_hend(out_hend),
        .out_vstart(out_vstart), .out_vend(out_vend), .out_metric(out_metric)
    );

    typedef struct {
        bit [4:0] flags;
        longint   data;
    } exp_t;

    exp_t  q[$];
    int    vectors = 0;
    int    miscompares = 0;
    string req_tag = "R1";
    int    thr_now = 0;
    int    mgx [16][64];
    int    mgy [16][64];
    int    mrow = 0, mcol = 0;
    int    wt [5][5] = '{'{0,1,2,1,0}, '{1,4,6,4,1}, '{2,6,8,6,2},
                         '{1,4,6,4,1}, '{0,1,2,1,0}};

    function automatic longint model(bit hs, bit vs, int gx, int gy);
        int ax, ay, axy, rr, cc, sx, sy, sxy;
        longint det, tr, m;
        if (hs) begin
            mcol = 0;
            mrow = vs ? 0 : mrow + 1;
        end else begin
            mcol = mcol + 1;
        end
        mgx[mrow][mcol] = gx;
        mgy[mrow][mcol] = gy;
        ax = 0; ay = 0; axy = 0;
        for (int k = 0; k < 5; k++) begin
            for (int j = 0; j < 5; j++) begin
                rr = mrow - k;
                cc = mcol - j;
                if (rr >= 0 && cc >= 0) begin   // R7 zero padding
                    ax  += wt[k][j] * mgx[rr][cc] * mgx[rr][cc];
                    ay  += wt[k][j] * mgy[rr][cc] * mgy[rr][cc];
                    axy += wt[k][j] * mgx[rr][cc] * mgy[rr][cc];
                end
            end
        end
        sx = ax >>> 6; sy = ay >>> 6; sxy = axy >>> 6;     // R3
        det = longint'(sx) * sy - longint'(sxy) * sxy;
        tr  = longint'(sx) + sy;
        m   = det - ((tr * tr) >>> 4);                     // R4
        if (m <= thr_now) return 0;                        // R5
        if (m > 65535)    return 65535;                    // R6
        return m;
    endfunction

    task automatic compare(exp_t e);
        bit [4:0] act;
        act = {out_valid, out_hstart, out_hend, out_vstart, out_vend};
        vectors++;
        if (act != e.flags) begin
            miscompares++;
            $display("FAIL R2 flags actual %b expected %b", act, e.flags);
        end else if (longint'(out_metric) != e.data) begin
            miscompares++;
            $display("FAIL %s metric actual %0d expected %0d", req_tag, out_metric, e.data);
        end
    endtask

    task automatic step(bit v, bit hs, bit he, bit vs, bit ve, int gx, int gy);
        exp_t e;
        @(negedge clk);
        if (q.size() >= LAT) compare(q.pop_front());
        in_valid = v; in_hstart = hs; in_hend = he; in_vstart = vs; in_vend = ve;
        in_gx = gx[GW-1:0];
        in_gy = gy[GW-1:0];
        e.flags = {v, hs, he, vs, ve};
        e.data  = v ? model(hs, vs, gx, gy) : 0;   // R8: idle cycles carry zero
        q.push_back(e);
    endtask

    function automatic int grad(int mode, int r, int c, bit y);
        case (mode)
            0: return int'($urandom_range(255)) - 128;
            1: return y ? 0 : 50;
            2: return y ? (((r & 1) != 0) ? 100 : -100) : ((((r + c) & 1) != 0) ? 127 : -128);
            default: return int'($urandom_range(80)) - 40;
        endcase
    endfunction

    task automatic run_frame(int w, int h, int mode, int gap_pct, int thr, string tag);
        req_tag = tag;
        thr_now = thr;
        thresh  = OW'(thr);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < w; c++) begin
                while (int'($urandom_range(99)) < gap_pct) step(0, 0, 0, 0, 0, 0, 0);
                step(1, c == 0, c == w - 1, r == 0 && c == 0, r == h - 1 && c == w - 1,
                     grad(mode, r, c, 0), grad(mode, r, c, 1));
            end
            for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0);
        end
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R8 watchdog actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        exp_t z;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        vectors++;
        if (out_valid || out_hstart || out_hend || out_vstart || out_vend || out_metric != '0) begin
            miscompares++;
            $display("FAIL R1 reset actual v=%b m=%0d expected v=0 m=0", out_valid, out_metric);
        end
        z.flags = '0;
        z.data  = 0;
        for (int i = 0; i < LAT; i++) q.push_back(z);

        run_frame(10, 6, 3, 0, 0, "R7");          // R7, R3: borders, small gradients
        run_frame(12, 7, 0, 30, 0, "R8");         // R8: idle gaps inside and between lines
        run_frame(10, 6, 3, 0, 2000, "R5");       // R5: threshold gating
        run_frame(9, 6, 2, 10, 0, "R6");          // R6: saturation
        run_frame(8, 5, 1, 0, 0, "R6");           // R6: negative score clipped to zero
        run_frame(20, 5, 0, 0, 0, "R4");          // R4: full-scale random score
        run_frame(MW, 5, 3, 5, 100, "R8");        // R8: line at maximum width

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule